// File: doc/BRIEF.md
# Audio Link Outgoing Frame Serializer

This block is the controller-side transmitter of a time-multiplexed serial audio link. It runs on the serial bit clock that the codec supplies. It divides that clock down to produce the frame sync, and it shifts a 256-bit frame out on one serial data line. Each frame opens with a 16-bit tag slot. Twelve 20-bit data slots follow it. A bit in the tag slot marks the matching data slot as valid, and the data line carries zeros for the whole of any slot that is not tagged.

Two sources feed the frame. The first is a register command: a read/write flag, a 7-bit register index and 16 bits of write data. The second is a stereo pair of 16-bit playback samples. Each source holds its valid signal until a one-cycle taken strobe answers it. Both sources are sampled at the frame boundary, which is the bit-clock edge that starts the tag phase, so a frame's contents stay fixed while it is sent. Slots 5 to 12 are always sent as zero with their tags cleared.

Top module: `aclink_tx_framer`

## Requirements
- R1: After the first frame starts, sync rises exactly once every 256 bit clocks, and consecutive frames follow with no gap.
- R2: In each frame, sync is high for the first 16 bit clocks (the tag phase) and low for the remaining 240 bit clocks (the data phase).
- R3: Bits go out MSB first: the 16 tag bits, then slots 1 to 12 of 20 bits each. Tag bit 15 is the frame-valid flag and tag bits 14 down to 3 are the tags of slots 1 to 12. Tag bits 2 to 0 are always 0.
- R4: The frame-valid tag bit is 1 exactly when at least one slot tag of that frame is 1.
- R5: A command accepted at a frame boundary sets the slot 1 tag. Slot 1 then carries the read flag in bit 19 (1 = read), the register index in bits 18 to 12, and zeros in bits 11 to 0.
- R6: An accepted write command sets the slot 2 tag, and slot 2 then carries the 16-bit write value in bits 19 to 4 with bits 3 to 0 zero. An accepted read command leaves the slot 2 tag at 0 and slot 2 at zero.
- R7: An accepted sample pair sets the tags of slots 3 and 4. These slots carry the left and right samples in bits 19 to 4 of their slots, with bits 3 to 0 zero.
- R8: Every slot whose tag is 0, and every bit of slots 5 to 12, is sent as 0.
- R9: Inputs are sampled only at a frame boundary. Each taken strobe pulses for one cycle, in the same cycle as the first tag bit, when its valid was high at that boundary. Input changes while a frame is being sent have no effect on that frame.
- R10: After reset, sync and serial data stay low for the first 256 bit clocks, until the bit counter reaches its first frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock from the codec; outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | A register command is offered |
| cmd_read | input | 1 | 1 = read command, 0 = write command |
| cmd_addr | input | 7 | Register index |
| cmd_wdata | input | 16 | Write value |
| cmd_taken | output | 1 | One-cycle strobe: the command was latched into the frame now starting |
| pcm_valid | input | 1 | A playback sample pair is offered |
| pcm_left | input | 16 | Left playback sample |
| pcm_right | input | 16 | Right playback sample |
| pcm_taken | output | 1 | One-cycle strobe: the sample pair was latched into the frame now starting |
| sync_o | output | 1 | Frame sync, high during the tag phase |
| sdata_o | output | 1 | Outgoing serial data, MSB first |

## Verification
The serializer is driven with an empty frame, a write command alone, a read command alone, a sample pair alone, and all-ones values on every source at once. These cases separate the tag logic of each slot: the empty frame must clear the frame-valid bit, and a read must leave slot 2 untagged and zero. They also show whether any field spills into the zero bits next to it. Random fields with random valid flags then run over back-to-back frames, which checks the 256-clock frame period. In those frames the data inputs are scrambled while each frame is being sent, to show that capture happens only at the boundary. An idle window after reset, with valids held high, checks that nothing is driven before the first frame boundary.

// File: rtl/aclink_tx_pkg.sv
package aclink_tx_pkg;

  // Link geometry
  parameter int TAG_W   = 16;
  parameter int SLOT_W  = 20;
  parameter int N_SLOTS = 12;

  // Payload widths
  parameter int REG_IDX_W = 7;
  parameter int REG_VAL_W = 16;
  parameter int SAMPLE_W  = 16;

  // Slot positions (zero-based index of data slots 1..12)
  localparam int IDX_CMD_ADDR = 0;
  localparam int IDX_CMD_DATA = 1;
  localparam int IDX_PCM_L    = 2;
  localparam int IDX_PCM_R    = 3;

  localparam int FRAME_W = TAG_W + N_SLOTS * SLOT_W;

endpackage

// File: rtl/aclink_frame_timer.sv
module aclink_frame_timer #(
  parameter int TAG_BITS   = 16,
  parameter int FRAME_BITS = 256
) (
  input  logic clk,
  input  logic rst,
  output logic load_o,
  output logic tag_next_o,
  output logic run_o
);

  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  // The frame boundary is the edge where the counter wraps.
  assign load_o  = (cnt_q == CNT_W'(FRAME_BITS - 1));
  assign cnt_nxt = load_o ? '0 : cnt_q + 1'b1;

  // Tells whether the bit driven at this edge belongs to the tag phase.
  assign tag_next_o = (cnt_nxt < CNT_W'(TAG_BITS));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      run_o <= 1'b0;
    end else begin
      cnt_q <= cnt_nxt;
      if (load_o) begin
        run_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/aclink_frame_builder.sv
module aclink_frame_builder
  import aclink_tx_pkg::*;
#(
  parameter int TAG_BITS  = 16,
  parameter int SLOT_BITS = 20,
  parameter int NUM_SLOTS = 12,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 16,
  parameter int PCM_W     = 16,
  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS
) (
  input  logic                  cmd_valid,
  input  logic                  cmd_read,
  input  logic [ADDR_W-1:0]     cmd_addr,
  input  logic [DATA_W-1:0]     cmd_wdata,
  input  logic                  pcm_valid,
  input  logic [PCM_W-1:0]      pcm_left,
  input  logic [PCM_W-1:0]      pcm_right,
  output logic [FRAME_BITS-1:0] frame_o
);

  localparam int ADDR_PAD = SLOT_BITS - 1 - ADDR_W;
  localparam int DATA_PAD = SLOT_BITS - DATA_W;
  localparam int PCM_PAD  = SLOT_BITS - PCM_W;

  logic [NUM_SLOTS-1:0] slot_tag;
  logic [SLOT_BITS-1:0] slot_word [NUM_SLOTS];
  logic [SLOT_BITS-1:0] slot_out  [NUM_SLOTS];
  logic [TAG_BITS-1:0]  tag_slot;

  // Per-slot content and tag; untagged slots are forced to zero.
  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    if (i == IDX_CMD_ADDR) begin : g_addr
      assign slot_tag[i]  = cmd_valid;
      assign slot_word[i] = {cmd_read, cmd_addr, {ADDR_PAD{1'b0}}};
    end else if (i == IDX_CMD_DATA) begin : g_wdat
      assign slot_tag[i]  = cmd_valid & ~cmd_read;
      assign slot_word[i] = {cmd_wdata, {DATA_PAD{1'b0}}};
    end else if (i == IDX_PCM_L) begin : g_left
      assign slot_tag[i]  = pcm_valid;
      assign slot_word[i] = {pcm_left, {PCM_PAD{1'b0}}};
    end else if (i == IDX_PCM_R) begin : g_right
      assign slot_tag[i]  = pcm_valid;
      assign slot_word[i] = {pcm_right, {PCM_PAD{1'b0}}};
    end else begin : g_unused
      assign slot_tag[i]  = 1'b0;
      assign slot_word[i] = '0;
    end
    assign slot_out[i] = slot_tag[i] ? slot_word[i] : '0;
  end

  always_comb begin
    tag_slot = '0;
    tag_slot[TAG_BITS-1] = |slot_tag;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      tag_slot[TAG_BITS-2-i] = slot_tag[i];
    end
  end

  always_comb begin
    frame_o = '0;
    frame_o[FRAME_BITS-1 -: TAG_BITS] = tag_slot;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      frame_o[FRAME_BITS-1-TAG_BITS-i*SLOT_BITS -: SLOT_BITS] = slot_out[i];
    end
  end

endmodule

// File: rtl/aclink_serializer.sv
module aclink_serializer #(
  parameter int FRAME_BITS = 256
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load_i,
  input  logic                  tag_next_i,
  input  logic                  run_i,
  input  logic [FRAME_BITS-1:0] frame_i,
  output logic                  sync_o,
  output logic                  sdata_o
);

  logic [FRAME_BITS-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg_q <= '0;
      sdata_o <= 1'b0;
      sync_o  <= 1'b0;
    end else begin
      sync_o <= (load_i | run_i) & tag_next_i;
      if (load_i) begin
        sdata_o <= frame_i[FRAME_BITS-1];
        shreg_q <= {frame_i[FRAME_BITS-2:0], 1'b0};
      end else begin
        sdata_o <= run_i & shreg_q[FRAME_BITS-1];
        shreg_q <= {shreg_q[FRAME_BITS-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/aclink_tx_framer.sv
module aclink_tx_framer
  import aclink_tx_pkg::*;
#(
  parameter int TAG_BITS  = aclink_tx_pkg::TAG_W,
  parameter int SLOT_BITS = aclink_tx_pkg::SLOT_W,
  parameter int NUM_SLOTS = aclink_tx_pkg::N_SLOTS,
  parameter int ADDR_W    = aclink_tx_pkg::REG_IDX_W,
  parameter int DATA_W    = aclink_tx_pkg::REG_VAL_W,
  parameter int PCM_W     = aclink_tx_pkg::SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic              cmd_read,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              cmd_taken,
  input  logic              pcm_valid,
  input  logic [PCM_W-1:0]  pcm_left,
  input  logic [PCM_W-1:0]  pcm_right,
  output logic              pcm_taken,
  output logic              sync_o,
  output logic              sdata_o
);

  localparam int FRAME_BITS = TAG_BITS + NUM_SLOTS * SLOT_BITS;

  logic                  load;
  logic                  tag_next;
  logic                  run;
  logic [FRAME_BITS-1:0] frame;

  aclink_frame_timer #(
    .TAG_BITS  (TAG_BITS),
    .FRAME_BITS(FRAME_BITS)
  ) timer_i (
    .clk       (clk),
    .rst       (rst),
    .load_o    (load),
    .tag_next_o(tag_next),
    .run_o     (run)
  );

  aclink_frame_builder #(
    .TAG_BITS (TAG_BITS),
    .SLOT_BITS(SLOT_BITS),
    .NUM_SLOTS(NUM_SLOTS),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PCM_W    (PCM_W)
  ) builder_i (
    .cmd_valid(cmd_valid),
    .cmd_read (cmd_read),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .pcm_valid(pcm_valid),
    .pcm_left (pcm_left),
    .pcm_right(pcm_right),
    .frame_o  (frame)
  );

  aclink_serializer #(
    .FRAME_BITS(FRAME_BITS)
  ) ser_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load),
    .tag_next_i(tag_next),
    .run_i     (run),
    .frame_i   (frame),
    .sync_o    (sync_o),
    .sdata_o   (sdata_o)
  );

  // Taken strobes rise with the first tag bit of the frame that holds the data.
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_taken <= 1'b0;
      pcm_taken <= 1'b0;
    end else begin
      cmd_taken <= load & cmd_valid;
      pcm_taken <= load & pcm_valid;
    end
  end

endmodule

// File: rtl/aclink_tx_checker.sv
module aclink_tx_checker #(
  parameter int TAG_BITS   = 16,
  parameter int FRAME_BITS = 256,
  parameter int RSV_START  = 80
) (
  input logic clk,
  input logic rst,
  input logic sync_o,
  input logic sdata_o,
  input logic cmd_taken,
  input logic pcm_taken
);

  localparam int CW = $clog2(FRAME_BITS) + 1;

  logic [CW-1:0] hi_cnt;
  logic [CW-1:0] lo_cnt;
  logic          seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= '0;
      lo_cnt <= '0;
      seen   <= 1'b0;
    end else begin
      hi_cnt <= sync_o ? hi_cnt + 1'b1 : '0;
      lo_cnt <= sync_o ? '0 : lo_cnt + 1'b1;
      seen   <= seen | sync_o;
    end
  end

  AST_TAG_PHASE_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(sync_o) |-> hi_cnt == CW'(TAG_BITS)); // R2

  AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (rst)
    ($rose(sync_o) && seen) |-> lo_cnt == CW'(FRAME_BITS - TAG_BITS)); // R1

  AST_RSVD_TAG_ZERO: assert property (@(posedge clk) disable iff (rst)
    (sync_o && hi_cnt >= CW'(TAG_BITS - 3)) |-> !sdata_o); // R3

  AST_FRAME_VALID_TAG: assert property (@(posedge clk) disable iff (rst)
    (sync_o && hi_cnt == CW'(4)) |->
      ($past(sdata_o, 4) == ($past(sdata_o, 3) | $past(sdata_o, 2) |
                             $past(sdata_o, 1) | sdata_o))); // R4

  AST_UNUSED_SLOTS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!sync_o && seen && lo_cnt >= CW'(RSV_START)) |-> !sdata_o); // R8

  AST_CMD_TAKEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    cmd_taken |-> $rose(sync_o)); // R9

  AST_PCM_TAKEN_AT_BOUNDARY: assert property (@(posedge clk) disable iff (rst)
    pcm_taken |-> $rose(sync_o)); // R9

  AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
    (!seen && !sync_o) |-> !sdata_o); // R10

endmodule

bind aclink_tx_framer aclink_tx_checker #(
  .TAG_BITS  (TAG_BITS),
  .FRAME_BITS(FRAME_BITS),
  .RSV_START (4 * SLOT_BITS)
) chk_i (
  .clk      (clk),
  .rst      (rst),
  .sync_o   (sync_o),
  .sdata_o  (sdata_o),
  .cmd_taken(cmd_taken),
  .pcm_taken(pcm_taken)
);

// File: tb/aclink_tx_framer_tb.sv
module aclink_tx_framer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_read = 1'b0;
  logic [6:0]  cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        cmd_taken;
  logic        pcm_valid = 1'b0;
  logic [15:0] pcm_left = '0;
  logic [15:0] pcm_right = '0;
  logic        pcm_taken;
  logic        sync_o;
  logic        sdata_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  aclink_tx_framer dut_i (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_read (cmd_read),
    .cmd_addr (cmd_addr),
    .cmd_wdata(cmd_wdata),
    .cmd_taken(cmd_taken),
    .pcm_valid(pcm_valid),
    .pcm_left (pcm_left),
    .pcm_right(pcm_right),
    .pcm_taken(pcm_taken),
    .sync_o   (sync_o),
    .sdata_o  (sdata_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [255:0] exp_frame(input logic cv, input logic rd,
      input logic [6:0] a, input logic [15:0] wd, input logic pv,
      input logic [15:0] l, input logic [15:0] r);
    logic [15:0] tag;
    logic [19:0] s1, s2, s3, s4;
    logic t1, t2, t34;
    t1  = cv;
    t2  = cv & ~rd;
    t34 = pv;
    tag = {t1 | t2 | t34, t1, t2, t34, t34, 11'b0};
    s1  = t1  ? {rd, a, 12'b0} : 20'b0;
    s2  = t2  ? {wd, 4'b0}     : 20'b0;
    s3  = t34 ? {l, 4'b0}      : 20'b0;
    s4  = t34 ? {r, 4'b0}      : 20'b0;
    return {tag, s1, s2, s3, s4, 160'b0};
  endfunction

  // Offers the inputs, waits for the frame carrying them and checks it.
  task automatic run_frame(input logic cv, input logic rd, input logic [6:0] a,
      input logic [15:0] wd, input logic pv, input logic [15:0] l,
      input logic [15:0] r, input bit first, input bit scramble);
    logic [255:0] frm, sy, ex;
    int waits;
    cmd_valid = cv; cmd_read = rd; cmd_addr = a; cmd_wdata = wd;
    pcm_valid = pv; pcm_left = l; pcm_right = r;
    waits = 0;
    do begin
      @(negedge clk);
      waits++;
    end while (!sync_o && waits < 400);
    check(cmd_taken == cv, "R9", "cmd_taken at first tag bit", 256'(cmd_taken), 256'(cv));
    check(pcm_taken == pv, "R9", "pcm_taken at first tag bit", 256'(pcm_taken), 256'(pv));
    if (!first) check(waits == 1, "R1", "cycles to next frame", 256'(waits), 256'd1);
    cmd_valid = 1'b0;
    pcm_valid = 1'b0;
    frm[255] = sdata_o;
    sy[255]  = sync_o;
    for (int k = 1; k < 256; k++) begin
      @(negedge clk);
      frm[255-k] = sdata_o;
      sy[255-k]  = sync_o;
      if (k == 1) begin
        check(!cmd_taken && !pcm_taken, "R9", "taken strobes one cycle",
              256'({cmd_taken, pcm_taken}), 256'd0);
      end
      if (scramble && k == 100) begin
        cmd_read  = ~cmd_read;
        cmd_addr  = 7'($urandom);
        cmd_wdata = 16'($urandom);
        pcm_left  = 16'($urandom);
        pcm_right = 16'($urandom);
      end
    end
    ex = exp_frame(cv, rd, a, wd, pv, l, r);
    check(sy == {16'hffff, 240'b0}, "R2", "sync pattern", sy, {16'hffff, 240'b0});
    check(frm[255:240] == ex[255:240], "R3", "tag slot (R4 frame-valid)",
          256'(frm[255:240]), 256'(ex[255:240]));
    check(frm[239:220] == ex[239:220], "R5", "slot 1",
          256'(frm[239:220]), 256'(ex[239:220]));
    check(frm[219:200] == ex[219:200], "R6", "slot 2",
          256'(frm[219:200]), 256'(ex[219:200]));
    check(frm[199:160] == ex[199:160], "R7", "slots 3 and 4",
          256'(frm[199:160]), 256'(ex[199:160]));
    check(frm[159:0] == 160'b0, "R8", "slots 5 to 12", 256'(frm[159:0]), 256'd0);
    if (scramble) check(frm == ex, "R9", "mid-frame input change ignored", frm, ex);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    // Valids held high during the idle window: no output may appear (R10)
    cmd_valid = 1'b1; pcm_valid = 1'b1; cmd_wdata = 16'hffff; pcm_left = 16'hffff;
    rst = 1'b0;
    begin
      bit quiet;
      quiet = 1'b1;
      for (int k = 0; k < 250; k++) begin
        @(negedge clk);
        if (sync_o || sdata_o || cmd_taken || pcm_taken) quiet = 1'b0;
      end
      check(quiet, "R10", "idle after reset", 256'(quiet), 256'd1);
    end
    // Directed corner cases
    run_frame(1'b0, 1'b0, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b1, 1'b0);
    run_frame(1'b1, 1'b0, 7'h2c, 16'ha5c3, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    run_frame(1'b1, 1'b1, 7'h7f, 16'hffff, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b0);
    run_frame(1'b0, 1'b0, 7'h00, 16'h0000, 1'b1, 16'h8001, 16'h7ffe, 1'b0, 1'b0);
    run_frame(1'b1, 1'b0, 7'h7f, 16'hffff, 1'b1, 16'hffff, 16'hffff, 1'b0, 1'b1);
    run_frame(1'b0, 1'b0, 7'h00, 16'h0000, 1'b0, 16'h0000, 16'h0000, 1'b0, 1'b1);
    // Random frames, back to back
    for (int n = 0; n < 20; n++) begin
      run_frame(1'($urandom), 1'($urandom), 7'($urandom), 16'($urandom),
                1'($urandom), 16'($urandom), 16'($urandom), 1'b0, 1'b1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R1 watchdog expired actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule